// File: doc/BRIEF.md
# Packed Dual-Entry Color Palette

This block is a color lookup table with 256 logical entries. The bus side sees it as 128 writable 32-bit words. Each word carries two 16-bit color entries, one in its lower half and one in its upper half. A bus read returns a raw word exactly as it was written, one clock after the address is presented.

The lookup side takes an 8-bit pixel index and returns a 24-bit RGB value one clock later. Each 16-bit entry holds three 5-bit components and an intensity flag. The flag is kept in storage but plays no part in the color. Each component is widened to 8 bits by a left shift of three places, so the new low bits are zero. A swap input exchanges the red and blue output components.

The block has no state machine. It is a word array, a half-word selector, a component widener and two output registers.

Top module: `pal_lut`

## Requirements
- R1: While `rst_n` is low, every stored word is cleared to zero. In the first cycle after reset, `rd_data` and `lk_rgb` read zero.
- R2: On a rising clock edge with `wr_en` high, `wr_data` is stored into word `wr_addr`. No other word changes.
- R3: `rd_data` presents, one clock after `rd_addr` is sampled, the full 32-bit word stored at that address. Bit 15 and bit 31 are returned unchanged.
- R4: Index i selects word i[7:1]. When i[0] is 0 the entry is bits [15:0] of that word. When i[0] is 1 it is bits [31:16].
- R5: Within an entry, bits [4:0] are red, bits [9:5] are green and bits [14:10] are blue. On the output, `lk_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R6: Each 8-bit output component equals its 5-bit field shifted left by three. Bits [2:0], [10:8] and [18:16] of `lk_rgb` are always zero.
- R7: Bit 15 of an entry has no effect on `lk_rgb`.
- R8: `lk_rgb` is registered with one clock of latency. A lookup sampled on the same edge as a write to its word returns the old contents. A lookup sampled on the next edge returns the new contents.
- R9: When `lk_swap` is high at the sampling edge, the red and blue components of that result are exchanged. Green is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 7 | Word address for writes |
| wr_data | input | 32 | Raw word to store |
| rd_addr | input | 7 | Word address for bus reads |
| rd_data | output | 32 | Raw word read back, registered |
| lk_idx | input | 8 | Pixel index into the 256 entries |
| lk_swap | input | 1 | Exchange red and blue on the output |
| lk_rgb | output | 24 | Expanded color, registered |

## Verification
The bench uses the default parameters: 128 words of 32 bits, which give 256 entries of 16 bits. With these values the full index range, including entry 255 in the upper half of the last word, can be reached in a short run. The bench keeps its own copy of the words, so a same-edge write followed by a lookup can be compared against both the old contents and the new. Random traffic mixes writes, reads, lookups and swap settings, including words with the intensity bit set. Directed steps cover the reset value, both halves of a word, each color component on its own, and the red/blue exchange.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int COMP_IN_W  = 5;
    localparam int COMP_OUT_W = 8;
    localparam int ENTRY_W    = 16;
    localparam int RGB_W      = 3 * COMP_OUT_W;

    typedef struct packed {
        logic                 intensity;
        logic [COMP_IN_W-1:0] blu;
        logic [COMP_IN_W-1:0] grn;
        logic [COMP_IN_W-1:0] red;
    } pal_entry_t;

    typedef struct packed {
        logic [COMP_OUT_W-1:0] red;
        logic [COMP_OUT_W-1:0] grn;
        logic [COMP_OUT_W-1:0] blu;
    } rgb_t;

    function automatic logic [COMP_OUT_W-1:0] widen(input logic [COMP_IN_W-1:0] c);
        return {c, {(COMP_OUT_W - COMP_IN_W){1'b0}}};
    endfunction
endpackage

// File: rtl/pal_store.sv
module pal_store #(
    parameter  int WORDS  = 128,
    parameter  int WORD_W = 32,
    localparam int AW     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     bus_addr,
    output logic [WORD_W-1:0] bus_word,
    input  logic [AW-1:0]     lk_addr,
    output logic [WORD_W-1:0] lk_word
);
    logic [WORD_W-1:0] words_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                words_q[i] <= '0;
            end
        end else if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    assign bus_word = words_q[bus_addr];
    assign lk_word  = words_q[lk_addr];
endmodule

// File: rtl/pal_unpack.sv
module pal_unpack
    import pal_pkg::*;
#(
    parameter  int WORD_W = 32,
    localparam int NENT   = WORD_W / ENTRY_W,
    localparam int HW     = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [HW-1:0]     half,
    output pal_entry_t        entry
);
    pal_entry_t slots [NENT];

    genvar g;
    generate
        for (g = 0; g < NENT; g++) begin : g_slot
            assign slots[g] = pal_entry_t'(word[g*ENTRY_W +: ENTRY_W]);
        end
    endgenerate

    assign entry = slots[half];
endmodule

// File: rtl/pal_expand.sv
module pal_expand
    import pal_pkg::*;
(
    input  pal_entry_t entry,
    input  logic       swap,
    output rgb_t       rgb
);
    logic [COMP_OUT_W-1:0] wide_r;
    logic [COMP_OUT_W-1:0] wide_g;
    logic [COMP_OUT_W-1:0] wide_b;

    always_comb begin
        wide_r = widen(entry.red);
        wide_g = widen(entry.grn);
        wide_b = widen(entry.blu);
        rgb.grn = wide_g;
        if (swap) begin
            rgb.red = wide_b;
            rgb.blu = wide_r;
        end else begin
            rgb.red = wide_r;
            rgb.blu = wide_b;
        end
    end
endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_pkg::*;
#(
    parameter  int WORDS   = 128,
    parameter  int WORD_W  = 32,
    localparam int WADDR_W = $clog2(WORDS),
    localparam int NENT    = WORD_W / ENTRY_W,
    localparam int HW      = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int IDX_W   = WADDR_W + HW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [WADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic               lk_swap,
    output logic [RGB_W-1:0]   lk_rgb
);
    logic [WORD_W-1:0] bus_word;
    logic [WORD_W-1:0] lk_word;
    pal_entry_t        sel_entry;
    rgb_t              rgb_d;
    logic [WORD_W-1:0] rd_data_q;
    rgb_t              lk_rgb_q;

    pal_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .bus_addr (rd_addr),
        .bus_word (bus_word),
        .lk_addr  (lk_idx[IDX_W-1:HW]),
        .lk_word  (lk_word)
    );

    pal_unpack #(.WORD_W(WORD_W)) u_unpack (
        .word  (lk_word),
        .half  (lk_idx[HW-1:0]),
        .entry (sel_entry)
    );

    pal_expand u_expand (
        .entry (sel_entry),
        .swap  (lk_swap),
        .rgb   (rgb_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            lk_rgb_q  <= '0;
        end else begin
            rd_data_q <= bus_word;
            lk_rgb_q  <= rgb_d;
        end
    end

    assign rd_data = rd_data_q;
    assign lk_rgb  = lk_rgb_q;
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
    parameter int WORD_W  = 32,
    parameter int WADDR_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [WADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0]  wr_data,
    input logic [WADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0]  rd_data,
    input logic               lk_swap,
    input logic [15:0]        sel_entry,
    input logic [23:0]        lk_rgb
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_data == '0 && lk_rgb == '0));

    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rgb[2:0] == 3'b0 && lk_rgb[10:8] == 3'b0 && lk_rgb[18:16] == 3'b0));

    // R3
    raw_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(wr_en, 2) && $past(rd_addr) == $past(wr_addr, 2))
        |-> rd_data == $past(wr_data, 2));

    // R9
    red_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lk_rgb[23:19] == ($past(lk_swap) ? $past(sel_entry[14:10]) : $past(sel_entry[4:0])));

    // R9
    blue_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lk_rgb[7:3] == ($past(lk_swap) ? $past(sel_entry[4:0]) : $past(sel_entry[14:10])));

    // R5
    green_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lk_rgb[15:11] == $past(sel_entry[9:5]));
endmodule

bind pal_lut pal_lut_chk #(.WORD_W(WORD_W), .WADDR_W(WADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .lk_swap   (lk_swap),
    .sel_entry (sel_entry),
    .lk_rgb    (lk_rgb)
);

// File: tb/pal_lut_bench.sv
module pal_lut_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  lk_idx = '0;
    logic        lk_swap = 1'b0;
    logic [23:0] lk_rgb;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_lut u_pal_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .lk_idx  (lk_idx),
        .lk_swap (lk_swap),
        .lk_rgb  (lk_rgb)
    );

    function automatic logic [23:0] color_of(input logic [31:0] w, input logic hi, input logic sw);
        logic [15:0] e;
        logic [7:0]  r, g, b;
        e = hi ? w[31:16] : w[15:0];
        r = {e[4:0], 3'b000};
        g = {e[9:5], 3'b000};
        b = {e[14:10], 3'b000};
        return sw ? {b, g, r} : {r, g, b};
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives inputs, predicts, waits one cycle, checks.
    task automatic step(input logic we, input logic [6:0] wa, input logic [31:0] wd,
                        input logic [6:0] ra, input logic [7:0] idx, input logic sw,
                        input string rtag, input string ltag);
        logic [31:0] exp_rd;
        logic [23:0] exp_rgb;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr = ra; lk_idx = idx; lk_swap = sw;
        exp_rd  = model[ra];
        exp_rgb = color_of(model[idx[7:1]], idx[0], sw);
        if (we) model[wa] = wd;
        @(negedge clk);
        check32(rtag, rd_data, exp_rd);
        check32(ltag, {8'h00, lk_rgb}, {8'h00, exp_rgb});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [23:0] c_a, c_b;
        unused_seed = $urandom(32'd4242);
        for (int i = 0; i < WORDS; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        // R1: outputs zero while in reset
        check32("R1 reset rd", rd_data, 32'h0);
        check32("R1 reset rgb", {8'h00, lk_rgb}, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 7'd0, 32'h0, 7'd77, 8'd200, 1'b0, "R1 rd after reset", "R1 rgb after reset");

        // R2 R3: write then read back exactly, both intensity bits kept
        step(1'b1, 7'd3, 32'hA5A5_9234, 7'd0, 8'd0, 1'b0, "R3", "R8");
        step(1'b0, 7'd0, 32'h0, 7'd3, 8'd6, 1'b0, "R2 R3 readback", "R4 low half");
        step(1'b0, 7'd0, 32'h0, 7'd3, 8'd7, 1'b0, "R3", "R4 high half");

        // R8: lookup on the write edge sees old, next edge new
        step(1'b1, 7'd3, 32'h0000_7C1F, 7'd3, 8'd6, 1'b0, "R8 old rd", "R8 old rgb");
        step(1'b0, 7'd0, 32'h0, 7'd3, 8'd6, 1'b0, "R8 new rd", "R8 new rgb");

        // R5 R6: one component at a time
        step(1'b1, 7'd20, 32'h03E0_001F, 7'd0, 8'd0, 1'b0, "R3", "R5");
        step(1'b0, 7'd0, 32'h0, 7'd20, 8'd40, 1'b0, "R3", "R5 red only");
        check32("R5 red position", {8'h00, lk_rgb}, 32'h00F8_0000);
        step(1'b0, 7'd0, 32'h0, 7'd20, 8'd41, 1'b0, "R3", "R5 green only");
        check32("R6 green position", {8'h00, lk_rgb}, 32'h0000_F800);

        // R9: swap moves red to blue
        step(1'b0, 7'd0, 32'h0, 7'd20, 8'd40, 1'b1, "R3", "R9 swap");
        check32("R9 swapped red", {8'h00, lk_rgb}, 32'h0000_00F8);

        // R7: intensity bit has no effect
        step(1'b1, 7'd9, 32'h7FFF_FFFF, 7'd0, 8'd0, 1'b0, "R3", "R7");
        step(1'b0, 7'd0, 32'h0, 7'd9, 8'd18, 1'b0, "R3 intensity kept", "R7 flag set");
        c_a = lk_rgb;
        step(1'b0, 7'd0, 32'h0, 7'd9, 8'd19, 1'b0, "R3", "R7 flag clear");
        c_b = lk_rgb;
        check32("R7 same color", {8'h00, c_a}, {8'h00, c_b});
        check32("R7 value", {8'h00, c_a}, 32'h00F8_F8F8);

        // R4: last entry of last word
        step(1'b1, 7'd127, 32'h5432_0000, 7'd0, 8'd0, 1'b0, "R3", "R4");
        step(1'b0, 7'd0, 32'h0, 7'd127, 8'd255, 1'b0, "R3 last word", "R4 entry 255");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic        we;
            logic [6:0]  wa, ra;
            logic [7:0]  ix;
            logic [31:0] wd;
            logic        sw;
            we = ($urandom % 3) == 0;
            wa = 7'($urandom);
            wd = $urandom;
            ra = ($urandom % 4 == 0) ? wa : 7'($urandom);
            ix = ($urandom % 4 == 0) ? {wa, 1'($urandom)} : 8'($urandom);
            sw = 1'($urandom);
            step(we, wa, wd, ra, ix, sw, "R2 R3 random", "R5 R6 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule